// File: doc/BRIEF.md
# Total-Store-Order Write Buffer with Load Forwarding

This block sits between one hardware thread and a shared memory port. Stores from the thread are parked in a small first-in first-out buffer and retire to memory later, oldest first. A single request/grant port is shared by load reads and store retirement. Loads look into the buffer first. If one or more parked stores target the same address, the youngest of them supplies the value. Otherwise the load reads shared memory. Loads can therefore pass older stores to other addresses, but never a store to their own address.

A global lock held by some other thread is presented as one `blocked_i` input. While it is high the block neither reads memory nor retires stores, although forwarded loads and new stores still proceed. A fence request is acknowledged in the cycle the buffer is empty. The `empty_o` flag lets the lock logic decide when a locked operation may start or end. The buffer depth is a power-of-two parameter. A full buffer drops `st_ready_o`.

Top module: `tso_wbuf`

## Requirements
- R1: A store with `st_valid_i` high while `st_ready_o` is high is accepted at the clock edge as the newest buffer entry. This needs no input from other threads. `st_ready_o` is high whenever fewer than DEPTH entries are held.
- R2: When `ld_req_i` is high and `ld_addr_i` matches at least one held entry, `ld_ack_o` is high in the same cycle and `ld_data_o` carries the data of the youngest matching entry. No memory read is requested in that cycle.
- R3: When `ld_req_i` is high, no entry matches and `blocked_i` is low, the block issues a read: `mem_req_o`=1, `mem_we_o`=0, `mem_addr_o`=`ld_addr_i`. In the cycle `mem_gnt_i` is high, `ld_ack_o` is high and `ld_data_o` equals `mem_rdata_i`. While `blocked_i` is high, `mem_req_o` stays 0.
- R4: When no load read is wanted, the buffer is not empty and `blocked_i` is low, the block requests a write of the oldest entry: `mem_req_o`=1, `mem_we_o`=1, with `mem_addr_o` and `mem_wdata_o` taken from that entry. The entry leaves the buffer at an edge where `mem_gnt_i` is high.
- R5: Entries reach memory in the order their stores were accepted.
- R6: `fence_ack_o` is high exactly in the cycles where `fence_req_i` is high and the buffer is empty. Retirement continues while a fence waits.
- R7: With DEPTH entries held, `st_ready_o` is 0 and a store offered in that cycle is ignored. It never reaches memory.
- R8: A store accepted in the same cycle as a load lookup counts as younger than that load. The load does not see it.
- R9: While `rst_n` is low, `mem_req_o` is 0. After reset the buffer is empty.
- R10: `empty_o` is 1 exactly when the buffer holds no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| blocked_i | input | 1 | Global lock is held by another thread |
| st_valid_i | input | 1 | Store request |
| st_addr_i | input | ADDR_W | Store address |
| st_data_i | input | DATA_W | Store data |
| st_ready_o | output | 1 | Buffer can take a store |
| ld_req_i | input | 1 | Load lookup request |
| ld_addr_i | input | ADDR_W | Load address |
| ld_ack_o | output | 1 | Load value valid this cycle |
| ld_data_o | output | DATA_W | Load value |
| fence_req_i | input | 1 | Fence request |
| fence_ack_o | output | 1 | Fence completes this cycle |
| empty_o | output | 1 | Buffer holds no entry |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write (retire), 0 = read (load) |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_gnt_i | input | 1 | Memory access takes effect this cycle |
| mem_rdata_i | input | DATA_W | Memory read data, valid with grant |

## Verification
The bench stacks several stores to one address behind a held lock and loads that address. A search that picks the oldest match, or the first match in physical slot order, returns stale data. It offers a store to a full buffer: a block that overwrites a slot or moves its tail pointer would later retire a value that was never accepted. It drives a store and a load to the same address in the same cycle and expects the load to go to memory, which exposes a search that includes the incoming entry. It also raises the lock with stores pending and resets mid-run, where a design that ignores either still requests the memory port.

// File: rtl/tso_wbuf_pkg.sv
package tso_wbuf_pkg;

   // which client owns the shared memory port in a given cycle
   typedef enum logic [1:0] {
      PORT_IDLE  = 2'd0,
      PORT_LOAD  = 2'd1,
      PORT_DRAIN = 2'd2
   } port_sel_e;

   function automatic int unsigned ptr_bits(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/tso_wbuf_fifo.sv
module tso_wbuf_fifo #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 4,
   localparam int unsigned PW    = tso_wbuf_pkg::ptr_bits(DEPTH),
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push_i,
   input  logic [ADDR_W-1:0]        push_addr_i,
   input  logic [DATA_W-1:0]        push_data_i,
   input  logic                     pop_i,
   output logic [DEPTH*ADDR_W-1:0]  ent_addr_o,
   output logic [DEPTH*DATA_W-1:0]  ent_data_o,
   output logic [PW-1:0]            head_o,
   output logic [CW-1:0]            count_o,
   output logic                     full_o,
   output logic                     empty_o
);

   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];
   logic [PW-1:0]     head_q, tail_q;
   logic [CW-1:0]     cnt_q;

   assign full_o  = (cnt_q == CW'(DEPTH));
   assign empty_o = (cnt_q == '0);
   assign head_o  = head_q;
   assign count_o = cnt_q;

   // storage needs no reset: the count marks which slots are live
   always_ff @(posedge clk) begin
      if (push_i) begin
         addr_q[tail_q] <= push_addr_i;
         data_q[tail_q] <= push_data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push_i) tail_q <= tail_q + 1'b1;
         if (pop_i)  head_q <= head_q + 1'b1;
         case ({push_i, pop_i})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_flat
      assign ent_addr_o[gi*ADDR_W +: ADDR_W] = addr_q[gi];
      assign ent_data_o[gi*DATA_W +: DATA_W] = data_q[gi];
   end

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

   // R1
   cnt_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/tso_wbuf_fwd.sv
module tso_wbuf_fwd #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 4,
   localparam int unsigned PW    = tso_wbuf_pkg::ptr_bits(DEPTH),
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic [DEPTH*ADDR_W-1:0]  ent_addr_i,
   input  logic [DEPTH*DATA_W-1:0]  ent_data_i,
   input  logic [PW-1:0]            head_i,
   input  logic [CW-1:0]            count_i,
   input  logic [ADDR_W-1:0]        look_addr_i,
   output logic                     hit_o,
   output logic [DATA_W-1:0]        data_o
);

   logic [ADDR_W-1:0] a_arr [DEPTH];
   logic [DATA_W-1:0] d_arr [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_unpack
      assign a_arr[gi] = ent_addr_i[gi*ADDR_W +: ADDR_W];
      assign d_arr[gi] = ent_data_i[gi*DATA_W +: DATA_W];
   end

   // walk from oldest to youngest in age order; a later match overrides,
   // so the result is the youngest live entry for the address
   always_comb begin
      hit_o  = 1'b0;
      data_o = '0;
      for (int k = 0; k < DEPTH; k++) begin
         automatic logic [PW-1:0] slot = head_i + PW'(k);
         if ((CW'(k) < count_i) && (a_arr[slot] == look_addr_i)) begin
            hit_o  = 1'b1;
            data_o = d_arr[slot];
         end
      end
   end

endmodule

// File: rtl/tso_wbuf_port.sv
module tso_wbuf_port #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blocked_i,
   input  logic              ld_req_i,
   input  logic              ld_hit_i,
   input  logic [ADDR_W-1:0] ld_addr_i,
   input  logic              fifo_empty_i,
   input  logic [ADDR_W-1:0] head_addr_i,
   input  logic [DATA_W-1:0] head_data_i,
   input  logic              mem_gnt_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              rd_done_o,
   output logic              pop_o
);
   import tso_wbuf_pkg::*;

   port_sel_e sel;

   // a missing load outranks retirement; it cannot collide with a buffered
   // store because a miss means no entry holds its address
   always_comb begin
      if (!rst_n || blocked_i)          sel = PORT_IDLE;
      else if (ld_req_i && !ld_hit_i)   sel = PORT_LOAD;
      else if (!fifo_empty_i)           sel = PORT_DRAIN;
      else                              sel = PORT_IDLE;
   end

   assign mem_req_o   = (sel != PORT_IDLE);
   assign mem_we_o    = (sel == PORT_DRAIN);
   assign mem_addr_o  = (sel == PORT_LOAD) ? ld_addr_i : head_addr_i;
   assign mem_wdata_o = head_data_i;
   assign rd_done_o   = (sel == PORT_LOAD)  && mem_gnt_i;
   assign pop_o       = (sel == PORT_DRAIN) && mem_gnt_i;

   // R3
   blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blocked_i |-> !mem_req_o);

   // R4
   drain_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> !fifo_empty_i);

endmodule

// File: rtl/tso_wbuf.sv
module tso_wbuf #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blocked_i,
   input  logic              st_valid_i,
   input  logic [ADDR_W-1:0] st_addr_i,
   input  logic [DATA_W-1:0] st_data_i,
   output logic              st_ready_o,
   input  logic              ld_req_i,
   input  logic [ADDR_W-1:0] ld_addr_i,
   output logic              ld_ack_o,
   output logic [DATA_W-1:0] ld_data_o,
   input  logic              fence_req_i,
   output logic              fence_ack_o,
   output logic              empty_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic              mem_gnt_i,
   input  logic [DATA_W-1:0] mem_rdata_i
);

   localparam int unsigned PW = tso_wbuf_pkg::ptr_bits(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("tso_wbuf: DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("tso_wbuf: ADDR_W and DATA_W must be positive");
   end

   logic [DEPTH*ADDR_W-1:0] ent_addr;
   logic [DEPTH*DATA_W-1:0] ent_data;
   logic [PW-1:0]           head;
   logic [CW-1:0]           count;
   logic                    full, empty;
   logic                    push, pop;
   logic                    fwd_hit;
   logic [DATA_W-1:0]       fwd_data;
   logic                    rd_done;
   logic [ADDR_W-1:0]       head_addr;
   logic [DATA_W-1:0]       head_data;

   assign st_ready_o = !full;
   assign push       = st_valid_i && !full;

   tso_wbuf_fifo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push),
      .push_addr_i (st_addr_i),
      .push_data_i (st_data_i),
      .pop_i       (pop),
      .ent_addr_o  (ent_addr),
      .ent_data_o  (ent_data),
      .head_o      (head),
      .count_o     (count),
      .full_o      (full),
      .empty_o     (empty)
   );

   // lookup sees only entries present before this edge (R8)
   tso_wbuf_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_fwd (
      .ent_addr_i  (ent_addr),
      .ent_data_i  (ent_data),
      .head_i      (head),
      .count_i     (count),
      .look_addr_i (ld_addr_i),
      .hit_o       (fwd_hit),
      .data_o      (fwd_data)
   );

   assign head_addr = ent_addr[int'(head)*ADDR_W +: ADDR_W];
   assign head_data = ent_data[int'(head)*DATA_W +: DATA_W];

   tso_wbuf_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk          (clk),
      .rst_n        (rst_n),
      .blocked_i    (blocked_i),
      .ld_req_i     (ld_req_i),
      .ld_hit_i     (fwd_hit),
      .ld_addr_i    (ld_addr_i),
      .fifo_empty_i (empty),
      .head_addr_i  (head_addr),
      .head_data_i  (head_data),
      .mem_gnt_i    (mem_gnt_i),
      .mem_req_o    (mem_req_o),
      .mem_we_o     (mem_we_o),
      .mem_addr_o   (mem_addr_o),
      .mem_wdata_o  (mem_wdata_o),
      .rd_done_o    (rd_done),
      .pop_o        (pop)
   );

   assign ld_ack_o    = ld_req_i && (fwd_hit || rd_done);
   assign ld_data_o   = fwd_hit ? fwd_data : mem_rdata_i;
   assign fence_ack_o = fence_req_i && empty;
   assign empty_o     = empty;

   // R2
   fwd_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_req_i && fwd_hit) |-> !(mem_req_o && !mem_we_o));

   // R6
   fence_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fence_ack_o |-> !(mem_req_o && mem_we_o));

   // R7
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_ready_o && !(mem_req_o && mem_we_o && mem_gnt_i)) |=> !st_ready_o);

endmodule

// File: tb/tso_wbuf_bench.sv
module tso_wbuf_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int DEPTH = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          blocked = 1'b0;
   logic          st_valid = 1'b0;
   logic [AW-1:0] st_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic          st_ready;
   logic          ld_req = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic          ld_ack;
   logic [DW-1:0] ld_data;
   logic          fence_req = 1'b0;
   logic          fence_ack;
   logic          empty;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_gnt = 1'b0;
   logic [DW-1:0] mem_rdata;

   logic [DW-1:0] mem_m [1<<AW];
   logic [AW-1:0] q_a[$];
   logic [DW-1:0] q_d[$];

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign mem_rdata = mem_m[mem_addr];

   tso_wbuf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_tso_wbuf (
      .clk(clk), .rst_n(rst_n), .blocked_i(blocked),
      .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data),
      .st_ready_o(st_ready), .ld_req_i(ld_req), .ld_addr_i(ld_addr),
      .ld_ack_o(ld_ack), .ld_data_o(ld_data), .fence_req_i(fence_req),
      .fence_ack_o(fence_ack), .empty_o(empty), .mem_req_o(mem_req),
      .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
      .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] mem_init(input int a);
      return DW'(a * 37 + 5);
   endfunction

   // one cycle: drive at negedge, check combinational outputs, update model
   task automatic step(input bit blk, input bit stv, input logic [AW-1:0] sta,
                       input logic [DW-1:0] std, input bit ldr,
                       input logic [AW-1:0] lda, input bit fr, input bit gnt);
      bit hit, miss_rd, drain, exp_req, exp_ack;
      logic [DW-1:0] fwd, exp_data;
      int cnt;
      @(negedge clk);
      blocked = blk; st_valid = stv; st_addr = sta; st_data = std;
      ld_req = ldr; ld_addr = lda; fence_req = fr; mem_gnt = gnt;
      #1;
      cnt = q_a.size();
      hit = 1'b0; fwd = '0;
      foreach (q_a[i]) if (q_a[i] == lda) begin hit = 1'b1; fwd = q_d[i]; end
      miss_rd = ldr && !hit && !blk;
      drain   = !miss_rd && !blk && (cnt > 0);
      exp_req = miss_rd || drain;
      exp_ack = ldr && (hit || (miss_rd && gnt));
      exp_data = hit ? fwd : mem_m[lda];
      chk("R1", "st_ready", 32'(st_ready), 32'(cnt < DEPTH));
      chk("R10", "empty", 32'(empty), 32'(cnt == 0));
      chk("R6", "fence_ack", 32'(fence_ack), 32'(fr && cnt == 0));
      chk(blk ? "R3" : "R4", "mem_req", 32'(mem_req), 32'(exp_req));
      if (exp_req) begin
         chk(miss_rd ? "R3" : "R4", "mem_we", 32'(mem_we), 32'(drain));
         chk(miss_rd ? "R3" : "R5", "mem_addr", 32'(mem_addr),
             32'(miss_rd ? lda : q_a[0]));
         if (drain) chk("R5", "mem_wdata", 32'(mem_wdata), 32'(q_d[0]));
      end
      chk(hit ? "R2" : "R3", "ld_ack", 32'(ld_ack), 32'(exp_ack));
      if (exp_ack) chk(hit ? "R2" : "R3", "ld_data", 32'(ld_data), 32'(exp_data));
      // model update, load already evaluated before the new store (R8)
      if (drain && gnt) begin
         mem_m[q_a[0]] = q_d[0];
         void'(q_a.pop_front());
         void'(q_d.pop_front());
      end
      if (stv && cnt < DEPTH) begin
         q_a.push_back(sta);
         q_d.push_back(std);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; blocked = 1'b0; ld_req = 1'b1; ld_addr = 8'hF0;
      st_valid = 1'b0; fence_req = 1'b0; mem_gnt = 1'b1;
      #1;
      chk("R9", "mem_req_in_reset", 32'(mem_req), 32'd0);
      @(negedge clk);
      #1;
      chk("R9", "mem_req_in_reset2", 32'(mem_req), 32'd0);
      rst_n = 1'b1; ld_req = 1'b0; mem_gnt = 1'b0;
      q_a.delete(); q_d.delete();
      #1;
      chk("R9", "empty_after_reset", 32'(empty), 32'd1);
      chk("R9", "ready_after_reset", 32'(st_ready), 32'd1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int a = 0; a < (1 << AW); a++) mem_m[a] = mem_init(a);
      do_reset();

      // held lock: stack stores to one address, then fill (R1, R7)
      step(1, 1, 8'd5, 16'hA001, 0, 8'd0, 0, 1);
      step(1, 1, 8'd5, 16'hA002, 0, 8'd0, 0, 1);
      step(1, 1, 8'd6, 16'hC003, 0, 8'd0, 0, 1);
      step(1, 1, 8'd5, 16'hD004, 0, 8'd0, 0, 1);
      // full: this store must be dropped (R7)
      step(1, 1, 8'd7, 16'hEEEE, 0, 8'd0, 0, 1);
      // youngest forward while blocked (R2)
      step(1, 0, 8'd0, 16'h0, 1, 8'd5, 0, 1);
      step(1, 0, 8'd0, 16'h0, 1, 8'd6, 0, 1);
      // miss while blocked: no request, no ack (R3)
      step(1, 0, 8'd0, 16'h0, 1, 8'd9, 0, 1);
      // fence waits on a non-empty buffer (R6)
      step(1, 0, 8'd0, 16'h0, 0, 8'd0, 1, 1);
      // unblock without grant: head held (R4)
      step(0, 0, 8'd0, 16'h0, 0, 8'd0, 1, 0);
      // miss read outranks retirement (R3)
      step(0, 0, 8'd0, 16'h0, 1, 8'd9, 1, 1);
      // drain in order with the fence pending (R5, R6)
      for (int i = 0; i < 5; i++) step(0, 0, 8'd0, 16'h0, 0, 8'd0, 1, 1);
      chk("R7", "dropped_store_not_written", 32'(mem_m[7]), 32'(mem_init(7)));
      // same-cycle store and load, same address (R8)
      step(0, 1, 8'd20, 16'h1234, 1, 8'd20, 0, 1);
      step(1, 0, 8'd0, 16'h0, 1, 8'd20, 0, 0);
      step(0, 0, 8'd0, 16'h0, 0, 8'd0, 1, 1);
      step(0, 0, 8'd0, 16'h0, 0, 8'd0, 1, 1);

      // constrained random over a narrow address range
      for (int c = 0; c < 4000; c++) begin
         step(($urandom % 4) == 0, ($urandom % 2) == 0, AW'($urandom % 8),
              DW'($urandom), ($urandom % 2) == 0, AW'($urandom % 8),
              ($urandom % 8) == 0, ($urandom % 3) != 0);
      end

      // reset with entries pending (R9)
      step(1, 1, 8'd3, 16'h0303, 0, 8'd0, 0, 0);
      step(1, 1, 8'd4, 16'h0404, 0, 8'd0, 0, 0);
      do_reset();
      step(0, 0, 8'd0, 16'h0, 1, 8'd3, 0, 1);
      step(0, 0, 8'd0, 16'h0, 0, 8'd0, 1, 1);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule